// File: doc/BRIEF.md
# DFU class request controller

This block serves the class-specific control requests of the device firmware upgrade function in a full-speed USB device. A control endpoint decodes the setup packet and hands the five setup fields to the block as a one-cycle strobe. The block answers with a one-cycle stall, a reply record for the two status-reading requests, or a change of its own state. It never sees packet framing, descriptors or FIFO data. The control endpoint tells it when the data stage of a download or upload has ended and how many bytes an upload actually carried.

The block has two modes. In run-time mode the detach request is the only class request it honours. A detach arms a pending switch that takes effect on the next bus reset. In upgrade mode it runs the download, manifestation, upload, error and abort sequence of the class. It drives an enable for the image download, an enable for the image upload, the block number of the current transfer, the selected alternate setting and a one-cycle clear pulse to the firmware-handling application. The application returns a busy flag and a 4-bit completion code. The block folds both into the six-byte status reply.

Top module: `dfu_req_ctrl`

## Requirements
- R1: After synchronous reset the block is in run-time mode (`dfu_mode_o`=0) with state 0. Both transfer enables, the alternate setting, the stall and the reply strobe are low.
- R2: In run-time mode, a detach (type 0x21, request 0) moves the state to 1 and nothing else changes. Any other class request addressed to this interface stalls and leaves the state unchanged.
- R3: A bus reset in state 1 enters upgrade mode in state 2 (idle). A bus reset in upgrade mode without completed manifestation returns to state 2 with alternate setting 0. A bus reset that arrives in the same cycle as a setup strobe takes effect, and that setup is discarded.
- R4: In upgrade mode, the following requests stall, move the state to 10 (error) and set the reported status byte to 0x0F: a detach, an unknown request code, a request with the wrong direction type, or a request not valid in the current state.
- R5: A download (type 0x21, request 1) with wLength from 1 to MAX_XFER, issued in state 2 or 5, raises `dnload_en_o`, copies wValue to `block_num_o` and enters state 3. A data-done strobe clears `dnload_en_o`.
- R6: A download or an upload whose wLength exceeds MAX_XFER is rejected as in R4.
- R7: A status request (type 0xA1, request 3) returns six bytes: byte 0 is the status, bytes 1 to 3 are the poll timeout little-endian, byte 4 is the state after the request and byte 5 is 0. The poll timeout is POLL_MS when `app_busy_i` is high and 1 otherwise. In state 3 or 6 the completion code is applied: 0xF moves state 3 to 5 and state 6 to 2, 0x0 keeps the state, and any other code moves to state 10 with that code as status.
- R8: A zero-length download in state 5 enters state 6. In state 2 it is rejected as in R4.
- R9: An upload (type 0xA1, request 2) in state 2 or 9 with wLength from 1 to MAX_XFER raises `upload_en_o`, copies wValue to `block_num_o` and enters state 9. At data-done the enable drops, and a byte count below wLength returns the state to 2. A zero-length upload goes straight to state 2.
- R10: A clear-status request (type 0x21, request 4) in state 10 pulses `clear_status_o` for one cycle, returns the state to 2 and resets the status to 0. In any other state it is rejected as in R4.
- R11: A state request (type 0xA1, request 5) returns one byte holding the state and changes nothing. An abort (type 0x21, request 6) in state 2, 5 or 9 returns to state 2.
- R12: A set-interface request (type 0x01, request 11) in state 2 with wValue below ALT_NUM selects that alternate setting. Otherwise in upgrade mode it is rejected as in R4. Setups whose wIndex differs from IFACE_NUM, or whose type is none of 0x21, 0xA1 or set-interface, are ignored.
- R13: Once a status request in state 6 has seen code 0xF, the next bus reset returns the block to run-time mode in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_reset_i | input | 1 | One-cycle USB bus reset indication |
| setup_valid_i | input | 1 | One-cycle strobe: setup fields are valid |
| setup_type_i | input | 8 | bmRequestType |
| setup_req_i | input | 8 | bRequest |
| setup_value_i | input | 16 | wValue |
| setup_index_i | input | 16 | wIndex |
| setup_length_i | input | 16 | wLength |
| data_done_i | input | 1 | One-cycle strobe: data stage finished |
| data_len_i | input | 16 | Bytes moved in the finished data stage |
| app_busy_i | input | 1 | Application asks for the long poll timeout |
| app_status_i | input | 4 | Completion code: 0x0 running, 0xF done, other error |
| dfu_mode_o | output | 1 | 1 in upgrade mode |
| dfu_state_o | output | 4 | Class state code |
| alt_sel_o | output | ALT_W | Selected alternate setting |
| dnload_en_o | output | 1 | High during an image download transfer |
| upload_en_o | output | 1 | High during an image upload transfer |
| block_num_o | output | 16 | Block number of the last download/upload |
| clear_status_o | output | 1 | One-cycle pulse telling the application to clear its code |
| stall_o | output | 1 | One-cycle pulse: stall the request |
| reply_valid_o | output | 1 | One-cycle pulse: reply record ready |
| reply_len_o | output | 3 | Reply length in bytes (6 or 1) |
| reply_data_o | output | 48 | Reply bytes, byte 0 in bits 7:0 |

## Verification
A bus reset and a setup strobe can arrive in the same cycle. The bench drives a download setup on the very edge where the pending detach turns into a bus reset. It then expects upgrade mode in idle with no stall and no download enable, which shows that the reset won and the setup was dropped. The second coincidence is a status request that samples the completion code while it also moves the state. The bench sweeps all sixteen codes and checks that the reported state and status byte already reflect the transition taken in that same cycle.

// File: rtl/dfu_req_pkg.sv
package dfu_req_pkg;

    typedef enum logic [3:0] {
        ST_APP_IDLE   = 4'd0,
        ST_APP_DETACH = 4'd1,
        ST_IDLE       = 4'd2,
        ST_DN_SYNC    = 4'd3,
        ST_DN_IDLE    = 4'd5,
        ST_MAN_SYNC   = 4'd6,
        ST_UP_IDLE    = 4'd9,
        ST_ERROR      = 4'd10
    } dfu_state_e;

    typedef enum logic [3:0] {
        K_NONE, K_DETACH, K_DNLOAD, K_UPLOAD, K_GETSTATUS,
        K_CLRSTATUS, K_GETSTATE, K_ABORT, K_SETALT, K_BAD
    } req_kind_e;

    typedef struct packed {
        logic [7:0]  rtype;
        logic [7:0]  req;
        logic [15:0] value;
        logic [15:0] index;
        logic [15:0] length;
    } setup_t;

    localparam logic [7:0] RT_CLASS_OUT = 8'h21;
    localparam logic [7:0] RT_CLASS_IN  = 8'hA1;
    localparam logic [7:0] RT_STD_IF    = 8'h01;
    localparam logic [7:0] RQ_DETACH    = 8'd0;
    localparam logic [7:0] RQ_DNLOAD    = 8'd1;
    localparam logic [7:0] RQ_UPLOAD    = 8'd2;
    localparam logic [7:0] RQ_GETSTATUS = 8'd3;
    localparam logic [7:0] RQ_CLRSTATUS = 8'd4;
    localparam logic [7:0] RQ_GETSTATE  = 8'd5;
    localparam logic [7:0] RQ_ABORT     = 8'd6;
    localparam logic [7:0] RQ_SET_IF    = 8'd11;

    localparam logic [7:0] ERR_STALLED  = 8'h0F;
    localparam logic [3:0] CODE_RUNNING = 4'h0;
    localparam logic [3:0] CODE_DONE    = 4'hF;

    // States from which an abort returns cleanly to idle
    function automatic logic abortable(dfu_state_e s);
        return (s == ST_IDLE) || (s == ST_DN_IDLE) || (s == ST_UP_IDLE);
    endfunction

    function automatic logic [23:0] poll_ms(logic busy, int unsigned long_ms);
        return busy ? 24'(long_ms) : 24'd1;
    endfunction

endpackage

// File: rtl/dfu_req_decode.sv
module dfu_req_decode
    import dfu_req_pkg::*;
#(
    parameter int IFACE_NUM = 0,
    parameter int MAX_XFER  = 64
) (
    input  setup_t    su,
    output req_kind_e kind,
    output logic      too_long
);
    always_comb begin
        kind = K_NONE;
        if (su.index == 16'(IFACE_NUM)) begin
            if (su.rtype == RT_CLASS_OUT) begin
                case (su.req)
                    RQ_DETACH:    kind = K_DETACH;
                    RQ_DNLOAD:    kind = K_DNLOAD;
                    RQ_CLRSTATUS: kind = K_CLRSTATUS;
                    RQ_ABORT:     kind = K_ABORT;
                    default:      kind = K_BAD;
                endcase
            end else if (su.rtype == RT_CLASS_IN) begin
                case (su.req)
                    RQ_UPLOAD:    kind = K_UPLOAD;
                    RQ_GETSTATUS: kind = K_GETSTATUS;
                    RQ_GETSTATE:  kind = K_GETSTATE;
                    default:      kind = K_BAD;
                endcase
            end else if (su.rtype == RT_STD_IF && su.req == RQ_SET_IF) begin
                kind = K_SETALT;
            end
        end
    end

    assign too_long = su.length > 16'(MAX_XFER);
endmodule

// File: rtl/dfu_req_fsm.sv
module dfu_req_fsm
    import dfu_req_pkg::*;
#(
    parameter int ALT_NUM = 3,
    parameter int ALT_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             setup_valid,
    input  req_kind_e        kind,
    input  logic             too_long,
    input  logic [15:0]      su_value,
    input  logic [15:0]      su_length,
    input  logic [3:0]       app_code,
    input  logic             data_done,
    input  logic [15:0]      data_len,
    output logic             mode,
    output dfu_state_e       state,
    output dfu_state_e       n_state,
    output logic [7:0]       n_err,
    output logic [ALT_W-1:0] alt,
    output logic             dl_en,
    output logic             ul_en,
    output logic [15:0]      blk,
    output logic             clr,
    output logic             stall,
    output logic             want_status,
    output logic             want_state
);
    logic [7:0]       err;
    logic [15:0]      uplen, n_uplen, n_blk;
    logic             man_done, n_man, n_mode, n_dl, n_ul, n_clr, n_stall, bad;
    logic [ALT_W-1:0] n_alt;

    always_comb begin
        n_state = state;  n_err = err;    n_mode = mode;  n_alt = alt;
        n_dl = dl_en;     n_ul = ul_en;   n_blk = blk;    n_uplen = uplen;
        n_man = man_done; n_clr = 1'b0;   n_stall = 1'b0; bad = 1'b0;
        want_status = 1'b0; want_state = 1'b0;
        if (bus_reset) begin
            n_dl = 1'b0; n_ul = 1'b0; n_alt = '0; n_err = '0; n_man = 1'b0;
            if (!mode) begin
                if (state == ST_APP_DETACH) begin
                    n_mode = 1'b1; n_state = ST_IDLE;
                end
            end else if (man_done) begin
                n_mode = 1'b0; n_state = ST_APP_IDLE;
            end else begin
                n_state = ST_IDLE;
            end
        end else if (setup_valid && kind != K_NONE) begin
            if (!mode) begin
                if (kind == K_DETACH)      n_state = ST_APP_DETACH;
                else if (kind != K_SETALT) n_stall = 1'b1;
            end else begin
                n_dl = 1'b0; n_ul = 1'b0;
                case (kind)
                    K_DNLOAD:
                        if (too_long) bad = 1'b1;
                        else if (su_length == 16'd0) begin
                            if (state == ST_DN_IDLE) n_state = ST_MAN_SYNC;
                            else bad = 1'b1;
                        end else if (state == ST_IDLE || state == ST_DN_IDLE) begin
                            n_dl = 1'b1; n_blk = su_value; n_state = ST_DN_SYNC;
                        end else bad = 1'b1;
                    K_UPLOAD:
                        if (too_long || !(state == ST_IDLE || state == ST_UP_IDLE)) bad = 1'b1;
                        else begin
                            n_blk = su_value;
                            if (su_length == 16'd0) n_state = ST_IDLE;
                            else begin
                                n_ul = 1'b1; n_uplen = su_length; n_state = ST_UP_IDLE;
                            end
                        end
                    K_GETSTATUS: begin
                        want_status = 1'b1;
                        if (state == ST_DN_SYNC || state == ST_MAN_SYNC) begin
                            if (app_code == CODE_DONE) begin
                                n_state = (state == ST_DN_SYNC) ? ST_DN_IDLE : ST_IDLE;
                                n_man   = (state == ST_MAN_SYNC);
                            end else if (app_code != CODE_RUNNING) begin
                                n_state = ST_ERROR; n_err = {4'h0, app_code};
                            end
                        end
                    end
                    K_CLRSTATUS:
                        if (state == ST_ERROR) begin
                            n_clr = 1'b1; n_err = '0; n_state = ST_IDLE;
                        end else bad = 1'b1;
                    K_GETSTATE: want_state = 1'b1;
                    K_ABORT:
                        if (abortable(state)) n_state = ST_IDLE;
                        else bad = 1'b1;
                    K_SETALT:
                        if (state == ST_IDLE && su_value < 16'(ALT_NUM)) n_alt = su_value[ALT_W-1:0];
                        else bad = 1'b1;
                    default: bad = 1'b1;
                endcase
                if (bad) begin
                    n_stall = 1'b1; n_state = ST_ERROR; n_err = ERR_STALLED;
                end
            end
        end else if (data_done) begin
            n_dl = 1'b0;
            if (ul_en) begin
                n_ul = 1'b0;
                if (data_len < uplen) n_state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= 1'b0;  state <= ST_APP_IDLE; err <= '0;   alt <= '0;
            dl_en <= 1'b0; ul_en <= 1'b0;        blk <= '0;   uplen <= '0;
            man_done <= 1'b0; clr <= 1'b0;       stall <= 1'b0;
        end else begin
            mode <= n_mode;   state <= n_state;  err <= n_err; alt <= n_alt;
            dl_en <= n_dl;    ul_en <= n_ul;     blk <= n_blk; uplen <= n_uplen;
            man_done <= n_man; clr <= n_clr;     stall <= n_stall;
        end
    end
endmodule

// File: rtl/dfu_req_reply.sv
module dfu_req_reply
    import dfu_req_pkg::*;
#(
    parameter int POLL_MS = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        want_status,
    input  logic        want_state,
    input  logic [7:0]  status_byte,
    input  dfu_state_e  state_after,
    input  logic        busy,
    output logic        valid,
    output logic [2:0]  len,
    output logic [47:0] data
);
    logic [23:0] poll;
    assign poll = poll_ms(busy, POLL_MS);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0; len <= '0; data <= '0;
        end else begin
            valid <= want_status | want_state;
            if (want_status) begin
                len  <= 3'd6;
                data <= {8'h00, 4'h0, state_after, poll, status_byte};
            end else if (want_state) begin
                len  <= 3'd1;
                data <= {40'h0, 4'h0, state_after};
            end
        end
    end
endmodule

// File: rtl/dfu_req_ctrl.sv
module dfu_req_ctrl
    import dfu_req_pkg::*;
#(
    parameter int ALT_NUM   = 3,
    parameter int MAX_XFER  = 64,
    parameter int POLL_MS   = 20,
    parameter int IFACE_NUM = 0,
    localparam int ALT_W    = (ALT_NUM > 1) ? $clog2(ALT_NUM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset_i,
    input  logic             setup_valid_i,
    input  logic [7:0]       setup_type_i,
    input  logic [7:0]       setup_req_i,
    input  logic [15:0]      setup_value_i,
    input  logic [15:0]      setup_index_i,
    input  logic [15:0]      setup_length_i,
    input  logic             data_done_i,
    input  logic [15:0]      data_len_i,
    input  logic             app_busy_i,
    input  logic [3:0]       app_status_i,
    output logic             dfu_mode_o,
    output logic [3:0]       dfu_state_o,
    output logic [ALT_W-1:0] alt_sel_o,
    output logic             dnload_en_o,
    output logic             upload_en_o,
    output logic [15:0]      block_num_o,
    output logic             clear_status_o,
    output logic             stall_o,
    output logic             reply_valid_o,
    output logic [2:0]       reply_len_o,
    output logic [47:0]      reply_data_o
);
    setup_t     su;
    req_kind_e  kind;
    logic       too_long, want_status, want_state;
    dfu_state_e state, n_state;
    logic [7:0] n_err;

    assign su = '{rtype: setup_type_i, req: setup_req_i, value: setup_value_i,
                  index: setup_index_i, length: setup_length_i};

    dfu_req_decode #(.IFACE_NUM(IFACE_NUM), .MAX_XFER(MAX_XFER)) dec_i (
        .su(su), .kind(kind), .too_long(too_long)
    );

    dfu_req_fsm #(.ALT_NUM(ALT_NUM), .ALT_W(ALT_W)) fsm_i (
        .clk(clk), .rst(rst), .bus_reset(bus_reset_i), .setup_valid(setup_valid_i),
        .kind(kind), .too_long(too_long), .su_value(su.value), .su_length(su.length),
        .app_code(app_status_i), .data_done(data_done_i), .data_len(data_len_i),
        .mode(dfu_mode_o), .state(state), .n_state(n_state), .n_err(n_err),
        .alt(alt_sel_o), .dl_en(dnload_en_o), .ul_en(upload_en_o), .blk(block_num_o),
        .clr(clear_status_o), .stall(stall_o),
        .want_status(want_status), .want_state(want_state)
    );

    dfu_req_reply #(.POLL_MS(POLL_MS)) rep_i (
        .clk(clk), .rst(rst), .want_status(want_status), .want_state(want_state),
        .status_byte(n_err), .state_after(n_state), .busy(app_busy_i),
        .valid(reply_valid_o), .len(reply_len_o), .data(reply_data_o)
    );

    assign dfu_state_o = state;
endmodule

// File: rtl/dfu_req_ctrl_chk.sv
module dfu_req_ctrl_chk #(
    parameter int ALT_NUM = 3,
    parameter int ALT_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_reset_i,
    input logic             setup_valid_i,
    input logic             dfu_mode_o,
    input logic [3:0]       dfu_state_o,
    input logic [ALT_W-1:0] alt_sel_o,
    input logic             dnload_en_o,
    input logic             upload_en_o,
    input logic [15:0]      block_num_o,
    input logic             clear_status_o,
    input logic             stall_o,
    input logic             reply_valid_o,
    input logic [2:0]       reply_len_o
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dfu_mode_o && dfu_state_o == 4'd0 && !dnload_en_o && !upload_en_o));

    a_r2_runtime_states: assert property (@(posedge clk) disable iff (rst)
        !dfu_mode_o |-> dfu_state_o <= 4'd1);

    a_r3_mode_by_bus_reset: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dfu_mode_o != $past(dfu_mode_o)) |-> $past(bus_reset_i));

    a_r4_stall_no_reply: assert property (@(posedge clk) disable iff (rst)
        !(stall_o && reply_valid_o));

    a_r5_enables_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dnload_en_o && upload_en_o));

    a_r5_block_from_setup: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && block_num_o != $past(block_num_o)) |-> $past(setup_valid_i));

    a_r7_reply_len: assert property (@(posedge clk) disable iff (rst)
        reply_valid_o |-> (reply_len_o == 3'd6 || reply_len_o == 3'd1));

    a_r10_clear_single: assert property (@(posedge clk) disable iff (rst)
        clear_status_o |=> !clear_status_o);

    a_r10_clear_to_idle: assert property (@(posedge clk) disable iff (rst)
        clear_status_o |-> dfu_state_o == 4'd2);

    a_r12_alt_range: assert property (@(posedge clk) disable iff (rst)
        int'(alt_sel_o) < ALT_NUM);
endmodule

bind dfu_req_ctrl dfu_req_ctrl_chk #(.ALT_NUM(ALT_NUM), .ALT_W(ALT_W)) chk_i (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .setup_valid_i(setup_valid_i),
    .dfu_mode_o(dfu_mode_o), .dfu_state_o(dfu_state_o), .alt_sel_o(alt_sel_o),
    .dnload_en_o(dnload_en_o), .upload_en_o(upload_en_o), .block_num_o(block_num_o),
    .clear_status_o(clear_status_o), .stall_o(stall_o),
    .reply_valid_o(reply_valid_o), .reply_len_o(reply_len_o)
);

// File: tb/dfu_req_ctrl_tb_top.sv
module dfu_req_ctrl_tb_top;
    localparam int MAXX = 64;
    localparam int POLL = 20;
    localparam logic [7:0] TO = 8'h21, TI = 8'hA1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0, setup_valid = 1'b0, data_done = 1'b0, busy = 1'b0;
    logic [7:0]  s_type = '0, s_req = '0;
    logic [15:0] s_val = '0, s_idx = '0, s_len = '0, d_len = '0;
    logic [3:0]  code = 4'h0;
    logic mode, dl, ul, clr, stall, rv;
    logic [3:0]  st;
    logic [1:0]  alt;
    logic [15:0] blk;
    logic [2:0]  rlen;
    logic [47:0] rdata;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    dfu_req_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset), .setup_valid_i(setup_valid),
        .setup_type_i(s_type), .setup_req_i(s_req), .setup_value_i(s_val),
        .setup_index_i(s_idx), .setup_length_i(s_len), .data_done_i(data_done),
        .data_len_i(d_len), .app_busy_i(busy), .app_status_i(code),
        .dfu_mode_o(mode), .dfu_state_o(st), .alt_sel_o(alt), .dnload_en_o(dl),
        .upload_en_o(ul), .block_num_o(blk), .clear_status_o(clr), .stall_o(stall),
        .reply_valid_o(rv), .reply_len_o(rlen), .reply_data_o(rdata)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] t, input logic [7:0] r, input logic [15:0] v,
                        input logic [15:0] l, input logic [15:0] idx = 16'd0);
        s_type = t; s_req = r; s_val = v; s_len = l; s_idx = idx; setup_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic bus_rst();
        bus_reset = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic finish_data(input logic [15:0] n);
        d_len = n; data_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_done = 1'b0;
    endtask

    task automatic exp_status(input string tag, input logic [7:0] bst, input logic [23:0] poll, input logic [3:0] stt);
        chk(tag, "reply valid", 32'(rv), 1);
        chk(tag, "reply len", 32'(rlen), 6);
        chk(tag, "status byte", 32'(rdata[7:0]), 32'(bst));
        chk(tag, "poll timeout", 32'(rdata[31:8]), 32'(poll));
        chk(tag, "reply state", 32'(rdata[39:32]), 32'(stt));
        chk(tag, "string byte", 32'(rdata[47:40]), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1", "mode", 32'(mode), 0);
        chk("R1", "state", 32'(st), 0);
        chk("R1", "enables", 32'({dl, ul}), 0);
        chk("R1", "alt", 32'(alt), 0);
        chk("R1", "strobes", 32'({stall, rv, clr}), 0);

        // R2 every non-detach class request stalls in run-time mode
        for (int r = 1; r < 8; r++) begin
            send((r == 2 || r == 3 || r == 5) ? TI : TO, 8'(r), 16'd0, 16'd0);
            chk("R2", "runtime stall", 32'(stall), 1);
            chk("R2", "runtime state", 32'(st), 0);
        end
        send(TI, 8'd0, 16'd0, 16'd0);
        chk("R2", "detach wrong dir stall", 32'(stall), 1);
        // R12 foreign interface and standard requests ignored
        send(TO, 8'd0, 16'd0, 16'd0, 16'd1);
        chk("R12", "other iface stall", 32'(stall), 0);
        chk("R12", "other iface state", 32'(st), 0);
        send(8'h80, 8'd0, 16'd0, 16'd0);
        chk("R12", "std request stall", 32'(stall), 0);
        send(TO, 8'd0, 16'd0, 16'd0);
        chk("R2", "detach state", 32'(st), 1);
        chk("R2", "detach mode", 32'(mode), 0);
        chk("R2", "detach stall", 32'(stall), 0);

        // R3 bus reset together with a setup: reset wins, setup dropped
        s_type = TO; s_req = 8'd1; s_val = 16'd5; s_len = 16'd8; s_idx = '0;
        setup_valid = 1'b1;
        bus_rst();
        setup_valid = 1'b0;
        chk("R3", "mode after reset", 32'(mode), 1);
        chk("R3", "state after reset", 32'(st), 2);
        chk("R3", "setup dropped dl", 32'(dl), 0);
        chk("R3", "setup dropped stall", 32'(stall), 0);

        // R11 GETSTATE
        send(TI, 8'd5, 16'd0, 16'd1);
        chk("R11", "state reply valid", 32'(rv), 1);
        chk("R11", "state reply len", 32'(rlen), 1);
        chk("R11", "state reply byte", 32'(rdata[7:0]), 2);
        // R7 poll timeout selection
        busy = 1'b1;
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R7", 8'h00, 24'(POLL), 4'd2);
        busy = 1'b0;
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R7", 8'h00, 24'd1, 4'd2);

        // R12 alternate setting
        send(8'h01, 8'd11, 16'd2, 16'd0);
        chk("R12", "alt set", 32'(alt), 2);
        chk("R12", "alt stall", 32'(stall), 0);
        send(8'h01, 8'd11, 16'd3, 16'd0);
        chk("R12", "alt out of range stall", 32'(stall), 1);
        chk("R12", "alt out of range state", 32'(st), 10);
        chk("R12", "alt kept", 32'(alt), 2);
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R4", 8'h0F, 24'd1, 4'd10);
        // R10 clear status
        send(TO, 8'd4, 16'd0, 16'd0);
        chk("R10", "clear pulse", 32'(clr), 1);
        chk("R10", "clear state", 32'(st), 2);
        @(negedge clk);
        chk("R10", "clear pulse ends", 32'(clr), 0);
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R10", 8'h00, 24'd1, 4'd2);

        // R5 R6 R8 download length sweep from idle
        for (int n = 0; n <= MAXX + 3; n++) begin
            send(TO, 8'd1, 16'(n + 100), 16'(n));
            if (n == 0 || n > MAXX) begin
                chk(n == 0 ? "R8" : "R6", "dnload reject stall", 32'(stall), 1);
                chk(n == 0 ? "R8" : "R6", "dnload reject state", 32'(st), 10);
                chk(n == 0 ? "R8" : "R6", "dnload reject dl", 32'(dl), 0);
                send(TO, 8'd4, 16'd0, 16'd0);
            end else begin
                chk("R5", "dnload enable", 32'(dl), 1);
                chk("R5", "dnload state", 32'(st), 3);
                chk("R5", "dnload block", 32'(blk), 32'(n + 100));
                finish_data(16'(n));
                chk("R5", "dnload enable drop", 32'(dl), 0);
                code = 4'hF;
                send(TI, 8'd3, 16'd0, 16'd6);
                send(TO, 8'd6, 16'd0, 16'd0);
                chk("R11", "abort to idle", 32'(st), 2);
                code = 4'h0;
            end
        end

        // R7 completion-code sweep in download-sync
        for (int c = 0; c < 16; c++) begin
            send(TO, 8'd1, 16'd1, 16'd8);
            finish_data(16'd8);
            code = 4'(c);
            send(TI, 8'd3, 16'd0, 16'd6);
            if (c == 15) begin
                exp_status("R7", 8'h00, 24'd1, 4'd5);
                chk("R7", "done state", 32'(st), 5);
                send(TO, 8'd6, 16'd0, 16'd0);
            end else if (c == 0) begin
                exp_status("R7", 8'h00, 24'd1, 4'd3);
                chk("R7", "running state", 32'(st), 3);
                code = 4'hF;
                send(TI, 8'd3, 16'd0, 16'd6);
                send(TO, 8'd6, 16'd0, 16'd0);
            end else begin
                exp_status("R7", 8'(c), 24'd1, 4'd10);
                chk("R7", "error state", 32'(st), 10);
                send(TO, 8'd4, 16'd0, 16'd0);
            end
            chk("R7", "back to idle", 32'(st), 2);
        end

        // R8 manifestation, R13 return to run-time
        send(TO, 8'd1, 16'd9, 16'd4);
        finish_data(16'd4);
        code = 4'hF;
        send(TI, 8'd3, 16'd0, 16'd6);
        send(TO, 8'd1, 16'd10, 16'd0);
        chk("R8", "zero dnload state", 32'(st), 6);
        chk("R8", "zero dnload stall", 32'(stall), 0);
        code = 4'h0;
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R7", 8'h00, 24'd1, 4'd6);
        code = 4'hF;
        send(TI, 8'd3, 16'd0, 16'd6);
        exp_status("R13", 8'h00, 24'd1, 4'd2);
        bus_rst();
        chk("R13", "runtime mode", 32'(mode), 0);
        chk("R13", "runtime state", 32'(st), 0);
        send(TO, 8'd0, 16'd0, 16'd0);
        bus_rst();
        chk("R3", "re-enter dfu", 32'(mode), 1);

        // R9 upload
        send(TI, 8'd2, 16'd7, 16'd16);
        chk("R9", "upload enable", 32'(ul), 1);
        chk("R9", "upload state", 32'(st), 9);
        chk("R9", "upload block", 32'(blk), 7);
        finish_data(16'd16);
        chk("R9", "full upload enable", 32'(ul), 0);
        chk("R9", "full upload state", 32'(st), 9);
        send(TI, 8'd2, 16'd8, 16'd16);
        finish_data(16'd5);
        chk("R9", "short upload state", 32'(st), 2);
        send(TI, 8'd2, 16'd9, 16'd0);
        chk("R9", "zero upload state", 32'(st), 2);
        chk("R9", "zero upload enable", 32'(ul), 0);
        send(TI, 8'd2, 16'd9, 16'(MAXX + 1));
        chk("R6", "long upload stall", 32'(stall), 1);
        chk("R6", "long upload state", 32'(st), 10);
        send(TO, 8'd4, 16'd0, 16'd0);

        // R4 invalid requests in DFU mode
        send(TO, 8'd0, 16'd0, 16'd0);
        chk("R4", "detach in dfu stall", 32'(stall), 1);
        chk("R4", "detach in dfu state", 32'(st), 10);
        send(TO, 8'd4, 16'd0, 16'd0);
        send(TO, 8'd9, 16'd0, 16'd0);
        chk("R4", "unknown request stall", 32'(stall), 1);
        send(TO, 8'd4, 16'd0, 16'd0);
        send(TO, 8'd4, 16'd0, 16'd0);
        chk("R10", "clear in idle stall", 32'(stall), 1);
        chk("R10", "clear in idle no pulse", 32'(clr), 0);
        send(TO, 8'd4, 16'd0, 16'd0);
        // R11 abort from upload-idle
        send(TI, 8'd2, 16'd1, 16'd4);
        finish_data(16'd4);
        send(TO, 8'd6, 16'd0, 16'd0);
        chk("R11", "abort upload idle", 32'(st), 2);
        // R3 bus reset in DFU mode without manifestation
        send(8'h01, 8'd11, 16'd1, 16'd0);
        bus_rst();
        chk("R3", "dfu bus reset mode", 32'(mode), 1);
        chk("R3", "dfu bus reset state", 32'(st), 2);
        chk("R3", "dfu bus reset alt", 32'(alt), 0);

        summary();
    end
endmodule